// File: doc/BRIEF.md
# Hard Reset Exit Sequencer

This block steers a node controller out of hard reset. While the hard reset input is low it keeps the local logic, the processor and the memory path in reset and masks bus inputs. When the reset input rises, it releases local reset and latches the strap pins and the reset cause. It then starts link bring-up and the two address translation table initializers. After that it follows one of two paths.

When the reset came from a bus-init event, the block keeps configuration intact. It leaves the processor out of reset and toggles a bus-not-ready line until both tables report done. For any other cause it pulses clear strobes for the configuration classes. It holds the processor reset for a programmable number of clocks, standing for one millisecond, and captures the address bus into a capture register. A watchdog window flags a table initialization that runs late.

A single done output goes high once all active conditions are met: both tables finished, the mask window over, and, on the non-bus-init path, the processor hold over. Pulling the reset input low at any time, including shortly after release, aborts the sequence and restarts it from the held state.

Top module: `hrd_sequencer`

## Requirements
- R1: While `hard_rst_n` is low (sampled at a clock edge), `local_rst` is 1 from the next cycle on. On the first edge at which `hard_rst_n` is seen high, the block enters the run phase and `local_rst` drops to 0 in the following cycle.
- R2: `node_id` and `bus_id` take the values of `strap_node` and `strap_bus` sampled at the release edge. Strap changes at any other time have no effect.
- R3: On a bus-init release (`cause_bus_init`=1 at the release edge), `bnr_out` starts at 0 and inverts on every edge of the run phase until both table done flags are latched. `cpu_rst` is 0 throughout the run phase. On any other release `bnr_out` stays 0.
- R4: On a non-bus-init release, `cpu_rst` stays 1 for run-phase counts 0 to HOLD_CYC-1, and `cap_addr` loads `addr_bus` at the release edge. A bus-init release leaves `cap_addr` unchanged.
- R5: In the first run cycle of a non-bus-init release, the following strobes pulse for one cycle: `clr_plain`, `clr_save`, `clr_cfg_grp` (only when `keep_cfg` was 0 at release) and `clr_mem_grp` (only when `keep_mem` was 0 at release). On a bus-init release no clear strobe fires.
- R6: `link_start` pulses in the first run cycle. `link_enable` is 1 outside the held phase, except when `fw_present` and `cpu_present` were both 1 at release. In that case it stays 0 until `sw_link_en` has been seen at an edge, and rises in the next cycle.
- R7: `mem_rst` is 1 in the held and run phases and 0 once the sequence is done.
- R8: `tbl_start` pulses in the first run cycle. `tbl_done_a` and `tbl_done_b` are latched at run-phase edges. If both are not latched by the edge at run count TBL_LIMIT, `init_timeout` becomes 1 and stays 1 until the next reset assertion. A done sampled at the edge with count TBL_LIMIT-1 is in time.
- R9: `bus_in_mask` is 1 in the held phase and for run counts 0 to MASK_CYC-1, and 0 afterwards.
- R10: A `hard_rst_n` low during the run or done phase returns the block to the held phase at the next edge. It clears the table flags, the timeout, the bus-not-ready toggle and the software link enable, and `seq_done` is not reached from the aborted run.
- R11: The run phase moves to done at an edge where both table flags are latched, the run count is at least MASK_CYC and, on a non-bus-init path, at least HOLD_CYC. `seq_done` is 1 in the done phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hard_rst_n | input | 1 | Hard reset input, low means asserted |
| cause_bus_init | input | 1 | Reset was caused by a bus-init event |
| keep_cfg | input | 1 | Save bit protecting the configuration class |
| keep_mem | input | 1 | Save bit protecting the memory configuration class |
| fw_present | input | 1 | Local firmware present |
| cpu_present | input | 1 | Processor present |
| sw_link_en | input | 1 | Software enable for the links |
| strap_node | input | NODE_W | Node identifier strap |
| strap_bus | input | BUS_W | Bus identifier strap |
| addr_bus | input | ADDR_W | Address bus bits for capture |
| tbl_done_a | input | 1 | First translation table initializer done |
| tbl_done_b | input | 1 | Second translation table initializer done |
| local_rst | output | 1 | Local logic reset |
| cpu_rst | output | 1 | Processor reset and power-on configuration drive |
| mem_rst | output | 1 | Memory reset discarding posted writes |
| bus_in_mask | output | 1 | Mask for inputs from buses tristated in reset |
| bnr_out | output | 1 | Bus-not-ready toggle |
| link_start | output | 1 | Link initialization start pulse |
| link_enable | output | 1 | Link enable level |
| tbl_start | output | 1 | Table initialization start pulse |
| clr_plain | output | 1 | Clear unprotected non-sticky configuration |
| clr_cfg_grp | output | 1 | Clear configuration class |
| clr_mem_grp | output | 1 | Clear memory configuration class |
| clr_save | output | 1 | Clear both save bits |
| init_timeout | output | 1 | Table initialization exceeded the window |
| seq_done | output | 1 | Sequence complete |
| node_id | output | NODE_W | Latched node identifier |
| bus_id | output | BUS_W | Latched bus identifier |
| cap_addr | output | ADDR_W | Captured address bits |

## Verification
Two events can land on the same edge: a table done arriving and the timeout limit being reached. The bench drives a done at the edge of run count TBL_LIMIT-1, where it must suppress the timeout, and at run count TBL_LIMIT, where the timeout must still fire. A second coincidence is a reset reassertion close to release while the first-cycle strobes and start pulses are live. An abort ten cycles after release must leave the block held, with no done and with the flags cleared. A reference model steps along on every clock and judges each output against its own phase and count.

// File: rtl/hrd_pkg.sv
package hrd_pkg;

    typedef enum logic [1:0] {
        PH_HELD = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } hrd_phase_e;

    typedef struct packed {
        logic bus_init;
        logic keep_cfg;
        logic keep_mem;
        logic fw_gate;
    } hrd_cause_t;

    function automatic int unsigned hrd_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hrd_latch.sv
module hrd_latch
    import hrd_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int BUS_W  = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              bus_init,
    input  logic              keep_cfg,
    input  logic              keep_mem,
    input  logic              fw_present,
    input  logic              cpu_present,
    input  logic [NODE_W-1:0] strap_node,
    input  logic [BUS_W-1:0]  strap_bus,
    input  logic [ADDR_W-1:0] addr_bus,
    output hrd_cause_t        cause,
    output logic [NODE_W-1:0] node_id,
    output logic [BUS_W-1:0]  bus_id,
    output logic [ADDR_W-1:0] cap_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause    <= '0;
            node_id  <= '0;
            bus_id   <= '0;
            cap_addr <= '0;
        end else if (capture) begin
            cause.bus_init <= bus_init;
            cause.keep_cfg <= keep_cfg;
            cause.keep_mem <= keep_mem;
            cause.fw_gate  <= fw_present & cpu_present;
            node_id        <= strap_node;
            bus_id         <= strap_bus;
            if (!bus_init) begin
                cap_addr <= addr_bus;
            end
        end
    end

endmodule

// File: rtl/hrd_tables.sv
module hrd_tables #(
    parameter int TBL_LIMIT = 200,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             done_a,
    input  logic             done_b,
    output logic             both_done,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TBL_LIMIT);

    logic [1:0] seen_q;

    assign both_done = &seen_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen_q  <= '0;
            timeout <= 1'b0;
        end else if (run) begin
            if ((cnt >= LIMIT_V) && !both_done) begin
                timeout <= 1'b1;
            end
            seen_q <= seen_q | {done_b, done_a};
        end
    end

endmodule

// File: rtl/hrd_fsm.sv
module hrd_fsm
    import hrd_pkg::*;
#(
    parameter int MASK_CYC = 16,
    parameter int HOLD_CYC = 125000,
    parameter int CNT_TOP  = 125000,
    parameter int CNT_W    = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hard_rst_n,
    input  logic             bus_init,
    input  logic             both_done,
    output hrd_phase_e       phase,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] MASK_V = CNT_W'(MASK_CYC);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(CNT_TOP);

    logic finish;

    assign finish = both_done && (cnt >= MASK_V) && (bus_init || (cnt >= HOLD_V));

    always_ff @(posedge clk) begin
        if (rst || !hard_rst_n) begin
            phase <= PH_HELD;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_HELD: begin
                    phase <= PH_RUN;
                    cnt   <= '0;
                end
                PH_RUN: begin
                    if (finish) begin
                        phase <= PH_DONE;
                    end
                    if (cnt != TOP_V) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

endmodule

// File: rtl/hrd_sequencer.sv
module hrd_sequencer
    import hrd_pkg::*;
#(
    parameter int NODE_W    = 6,
    parameter int BUS_W     = 2,
    parameter int ADDR_W    = 12,
    parameter int MASK_CYC  = 16,
    parameter int HOLD_CYC  = 125000,
    parameter int TBL_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_n,
    input  logic              cause_bus_init,
    input  logic              keep_cfg,
    input  logic              keep_mem,
    input  logic              fw_present,
    input  logic              cpu_present,
    input  logic              sw_link_en,
    input  logic [NODE_W-1:0] strap_node,
    input  logic [BUS_W-1:0]  strap_bus,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic              tbl_done_a,
    input  logic              tbl_done_b,
    output logic              local_rst,
    output logic              cpu_rst,
    output logic              mem_rst,
    output logic              bus_in_mask,
    output logic              bnr_out,
    output logic              link_start,
    output logic              link_enable,
    output logic              tbl_start,
    output logic              clr_plain,
    output logic              clr_cfg_grp,
    output logic              clr_mem_grp,
    output logic              clr_save,
    output logic              init_timeout,
    output logic              seq_done,
    output logic [NODE_W-1:0] node_id,
    output logic [BUS_W-1:0]  bus_id,
    output logic [ADDR_W-1:0] cap_addr
);

    localparam int CNT_TOP = int'(hrd_max3(MASK_CYC, HOLD_CYC, TBL_LIMIT));
    localparam int CNT_W   = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] MASK_V = CNT_W'(MASK_CYC);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

    hrd_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    hrd_cause_t       cause;
    logic             both_done;
    logic             held, run, first, capture, restart;
    logic             bnr_q, sw_seen_q;

    assign held    = (phase == PH_HELD);
    assign run     = (phase == PH_RUN);
    assign first   = run && (cnt == '0);
    assign capture = held && hard_rst_n;
    assign restart = held || !hard_rst_n;

    hrd_latch #(
        .NODE_W(NODE_W),
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .bus_init   (cause_bus_init),
        .keep_cfg   (keep_cfg),
        .keep_mem   (keep_mem),
        .fw_present (fw_present),
        .cpu_present(cpu_present),
        .strap_node (strap_node),
        .strap_bus  (strap_bus),
        .addr_bus   (addr_bus),
        .cause      (cause),
        .node_id    (node_id),
        .bus_id     (bus_id),
        .cap_addr   (cap_addr)
    );

    hrd_fsm #(
        .MASK_CYC(MASK_CYC),
        .HOLD_CYC(HOLD_CYC),
        .CNT_TOP (CNT_TOP),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hard_rst_n(hard_rst_n),
        .bus_init  (cause.bus_init),
        .both_done (both_done),
        .phase     (phase),
        .cnt       (cnt)
    );

    hrd_tables #(
        .TBL_LIMIT(TBL_LIMIT),
        .CNT_W    (CNT_W)
    ) u_tables (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (run),
        .cnt      (cnt),
        .done_a   (tbl_done_a),
        .done_b   (tbl_done_b),
        .both_done(both_done),
        .timeout  (init_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bnr_q     <= 1'b0;
            sw_seen_q <= 1'b0;
        end else begin
            if (run && cause.bus_init && !both_done) begin
                bnr_q <= ~bnr_q;
            end
            if (sw_link_en) begin
                sw_seen_q <= 1'b1;
            end
        end
    end

    always_comb begin
        local_rst   = held;
        cpu_rst     = held || (run && !cause.bus_init && (cnt < HOLD_V));
        mem_rst     = (phase != PH_DONE);
        bus_in_mask = held || (run && (cnt < MASK_V));
        bnr_out     = bnr_q;
        link_start  = first;
        tbl_start   = first;
        link_enable = !held && (!cause.fw_gate || sw_seen_q);
        clr_plain   = first && !cause.bus_init;
        clr_save    = first && !cause.bus_init;
        clr_cfg_grp = first && !cause.bus_init && !cause.keep_cfg;
        clr_mem_grp = first && !cause.bus_init && !cause.keep_mem;
        seq_done    = (phase == PH_DONE);
    end

endmodule

// File: rtl/hrd_sequencer_chk.sv
module hrd_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic hard_rst_n,
    input logic local_rst,
    input logic cpu_rst,
    input logic mem_rst,
    input logic bus_in_mask,
    input logic bnr_out,
    input logic tbl_start,
    input logic link_enable,
    input logic seq_done
);

    AST_HELD_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        !hard_rst_n |=> local_rst); // R10

    AST_HELD_DRIVES_ALL: assert property (@(posedge clk) disable iff (rst)
        local_rst |-> (bus_in_mask && cpu_rst && mem_rst)); // R9

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (!bus_in_mask && !cpu_rst && !mem_rst && !local_rst)); // R11

    AST_NO_BNR_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst && !local_rst) |-> !bnr_out); // R3

    AST_TBL_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tbl_start |=> !tbl_start); // R8

    AST_LINK_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
        link_enable |-> !local_rst); // R6

endmodule

bind hrd_sequencer hrd_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hard_rst_n (hard_rst_n),
    .local_rst  (local_rst),
    .cpu_rst    (cpu_rst),
    .mem_rst    (mem_rst),
    .bus_in_mask(bus_in_mask),
    .bnr_out    (bnr_out),
    .tbl_start  (tbl_start),
    .link_enable(link_enable),
    .seq_done   (seq_done)
);

// File: tb/tb_hrd_sequencer.sv
module tb_hrd_sequencer;

    localparam int NODE_W    = 6;
    localparam int BUS_W     = 2;
    localparam int ADDR_W    = 12;
    localparam int MASK_CYC  = 16;
    localparam int HOLD_CYC  = 300;
    localparam int TBL_LIMIT = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hard_rst_n = 1'b0;
    logic cause_bus_init = 1'b0, keep_cfg = 1'b0, keep_mem = 1'b0;
    logic fw_present = 1'b0, cpu_present = 1'b0, sw_link_en = 1'b0;
    logic [NODE_W-1:0] strap_node = '0;
    logic [BUS_W-1:0]  strap_bus = '0;
    logic [ADDR_W-1:0] addr_bus = '0;
    logic tbl_done_a = 1'b0, tbl_done_b = 1'b0;

    logic local_rst, cpu_rst, mem_rst, bus_in_mask, bnr_out, link_start, link_enable;
    logic tbl_start, clr_plain, clr_cfg_grp, clr_mem_grp, clr_save, init_timeout, seq_done;
    logic [NODE_W-1:0] node_id;
    logic [BUS_W-1:0]  bus_id;
    logic [ADDR_W-1:0] cap_addr;

    hrd_sequencer #(
        .NODE_W(NODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
        .MASK_CYC(MASK_CYC), .HOLD_CYC(HOLD_CYC), .TBL_LIMIT(TBL_LIMIT)
    ) dut (
        .clk(clk), .rst(rst), .hard_rst_n(hard_rst_n), .cause_bus_init(cause_bus_init),
        .keep_cfg(keep_cfg), .keep_mem(keep_mem), .fw_present(fw_present),
        .cpu_present(cpu_present), .sw_link_en(sw_link_en), .strap_node(strap_node),
        .strap_bus(strap_bus), .addr_bus(addr_bus), .tbl_done_a(tbl_done_a),
        .tbl_done_b(tbl_done_b), .local_rst(local_rst), .cpu_rst(cpu_rst),
        .mem_rst(mem_rst), .bus_in_mask(bus_in_mask), .bnr_out(bnr_out),
        .link_start(link_start), .link_enable(link_enable), .tbl_start(tbl_start),
        .clr_plain(clr_plain), .clr_cfg_grp(clr_cfg_grp), .clr_mem_grp(clr_mem_grp),
        .clr_save(clr_save), .init_timeout(init_timeout), .seq_done(seq_done),
        .node_id(node_id), .bus_id(bus_id), .cap_addr(cap_addr)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit chk_on = 1'b0;

    // reference model state: phase 0 held, 1 run, 2 done
    int m_ph = 0, m_cnt = 0, m_node = 0, m_bus = 0, m_addr = 0;
    bit m_bi = 0, m_kc = 0, m_km = 0, m_gate = 0, m_da = 0, m_db = 0;
    bit m_to = 0, m_bnr = 0, m_sw = 0, m_both = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_node = 0; m_bus = 0; m_addr = 0;
            m_bi = 0; m_kc = 0; m_km = 0; m_gate = 0;
            m_da = 0; m_db = 0; m_to = 0; m_bnr = 0; m_sw = 0;
        end else if (!hard_rst_n) begin
            m_ph = 0; m_cnt = 0;
            m_da = 0; m_db = 0; m_to = 0; m_bnr = 0; m_sw = 0;
        end else if (m_ph == 0) begin
            m_ph = 1; m_cnt = 0;
            m_bi = cause_bus_init; m_kc = keep_cfg; m_km = keep_mem;
            m_gate = fw_present && cpu_present;
            m_node = int'(strap_node); m_bus = int'(strap_bus);
            if (!cause_bus_init) m_addr = int'(addr_bus);
            m_da = 0; m_db = 0; m_to = 0; m_bnr = 0; m_sw = 0;
        end else begin
            if (m_ph == 1) begin
                m_both = m_da && m_db;
                if (m_cnt >= TBL_LIMIT && !m_both) m_to = 1;
                if (m_bi && !m_both) m_bnr = !m_bnr;
                if (m_both && m_cnt >= MASK_CYC && (m_bi || m_cnt >= HOLD_CYC)) m_ph = 2;
                if (tbl_done_a) m_da = 1;
                if (tbl_done_b) m_db = 1;
                m_cnt++;
            end
            if (sw_link_en) m_sw = 1;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            chk("R1 local_rst", int'(local_rst), int'(m_ph == 0));
            chk("R2 node_id", int'(node_id), m_node);
            chk("R2 bus_id", int'(bus_id), m_bus);
            chk("R3 bnr_out", int'(bnr_out), int'(m_bnr));
            chk("R4 cpu_rst", int'(cpu_rst),
                int'(m_ph == 0 || (m_ph == 1 && !m_bi && m_cnt < HOLD_CYC)));
            chk("R4 cap_addr", int'(cap_addr), m_addr);
            chk("R5 clr_plain", int'(clr_plain), int'(m_ph == 1 && m_cnt == 0 && !m_bi));
            chk("R5 clr_save", int'(clr_save), int'(m_ph == 1 && m_cnt == 0 && !m_bi));
            chk("R5 clr_cfg_grp", int'(clr_cfg_grp),
                int'(m_ph == 1 && m_cnt == 0 && !m_bi && !m_kc));
            chk("R5 clr_mem_grp", int'(clr_mem_grp),
                int'(m_ph == 1 && m_cnt == 0 && !m_bi && !m_km));
            chk("R6 link_start", int'(link_start), int'(m_ph == 1 && m_cnt == 0));
            chk("R6 link_enable", int'(link_enable), int'(m_ph != 0 && (!m_gate || m_sw)));
            chk("R7 mem_rst", int'(mem_rst), int'(m_ph != 2));
            chk("R8 tbl_start", int'(tbl_start), int'(m_ph == 1 && m_cnt == 0));
            chk("R8 init_timeout", int'(init_timeout), int'(m_to));
            chk("R9 bus_in_mask", int'(bus_in_mask),
                int'(m_ph == 0 || (m_ph == 1 && m_cnt < MASK_CYC)));
            chk("R11 seq_done", int'(seq_done), int'(m_ph == 2));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic exit_reset(input bit bi, input bit fw, input bit cpu,
                              input bit kc, input bit km, input int node,
                              input int bus, input int addr, input int da_at,
                              input int db_at, input int sw_at, input int abort_at,
                              input int n, input int exp_done, input int exp_to);
        cause_bus_init = bi; fw_present = fw; cpu_present = cpu;
        keep_cfg = kc; keep_mem = km;
        strap_node = NODE_W'(node); strap_bus = BUS_W'(bus); addr_bus = ADDR_W'(addr);
        @(negedge clk); #1;
        hard_rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            tbl_done_a = (da_at >= 0) && (k >= da_at);
            tbl_done_b = (db_at >= 0) && (k >= db_at);
            sw_link_en = (k == sw_at);
            if (k == 3) begin
                // straps, cause and address move after release: R2, R4
                strap_node = ~strap_node; strap_bus = ~strap_bus;
                addr_bus = ~addr_bus; cause_bus_init = ~bi;
                keep_cfg = ~kc; keep_mem = ~km;
            end
            if (k == abort_at) hard_rst_n = 1'b0;
            if (abort_at >= 0 && k == abort_at + 1) begin
                chk("R10 held after abort", int'(local_rst), 1);
                chk("R10 no done after abort", int'(seq_done), 0);
            end
        end
        if (exp_done >= 0) chk("R11 done at end", int'(seq_done), exp_done);
        if (exp_to >= 0) chk("R8 timeout at end", int'(init_timeout), exp_to);
        hard_rst_n = 1'b0;
        tbl_done_a = 1'b0; tbl_done_b = 1'b0; sw_link_en = 1'b0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset local_rst", int'(local_rst), 1);
        chk("R7 reset mem_rst", int'(mem_rst), 1);
        chk("R9 reset bus_in_mask", int'(bus_in_mask), 1);
        chk("R11 reset seq_done", int'(seq_done), 0);
        #1 rst = 1'b0;
        chk_on = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // plain reset, config save kept
        exit_reset(0, 0, 0, 1, 0, 21, 2, 12'h5a3, 30, 50, -1, -1, 330, 1, 0);
        // bus-init reset toggles bus-not-ready
        exit_reset(1, 0, 0, 0, 0, 9, 1, 12'h111, 10, 25, -1, -1, 60, 1, 0);
        // firmware and processor present: links wait for software
        exit_reset(0, 1, 1, 0, 1, 40, 3, 12'hc0d, 5, 5, 40, -1, 330, 1, 0);
        // late table: done sampled at count TBL_LIMIT -> timeout
        exit_reset(1, 0, 0, 0, 0, 7, 0, 12'h222, 0, TBL_LIMIT, -1, -1, 240, 1, 1);
        // last allowed count TBL_LIMIT-1 -> no timeout
        exit_reset(1, 0, 0, 1, 1, 3, 2, 12'h333, TBL_LIMIT - 1, 0, -1, -1, 240, 1, 0);
        // abort inside the re-trigger window, then a full exit
        exit_reset(0, 0, 0, 0, 0, 17, 1, 12'h444, 2, 2, -1, 10, 20, 0, 0);
        exit_reset(0, 1, 0, 1, 1, 50, 0, 12'h9e7, 60, 2, -1, -1, 330, 1, 0);
        // gated links never enabled without software
        exit_reset(1, 1, 1, 0, 0, 63, 3, 12'hfff, 4, 8, -1, -1, 40, 1, 0);
        chk("R6 link gate held", int'(link_enable), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule